// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block decides how a processor core comes out of reset. It separates two reset causes. The first is a power-on reset, called cold. The second is the active-low reset pin pulled low while power is already present, called warm. After a cold reset the core is parked in a low-power state, and instruction fetch stays disabled until an external run pulse arrives. After a warm reset fetch restarts as soon as the pin is released. In both cases the instruction pointer restarts at the reset vector, which is address zero, where the firmware ROM is mapped.

The power-on indication is active low and is sampled synchronously; it also serves as the block's reset. The reset pin is asynchronous and passes through a two-stage synchronizer before the state machine sees it. A separate register-file reset output covers both hold states and a short tail after each of them, so that register contents are initialised before they are used.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n_i` is sampled low at a rising edge, the next cycle shows `fetch_en_o`=0, `low_pwr_o`=0 and `rf_rst_o`=1 (cold hold). This holds for any value on the other inputs.
- R2: After `por_n_i` goes high with the reset pin high, `low_pwr_o` rises on the third rising edge that samples `por_n_i` high. The cold path never goes straight to running.
- R3: A reset pin held low through and after the power-on release keeps the sequencer in cold hold (outputs as in R1) until the pin is released. The release then leads to low power, not to run.
- R4: In low power, `low_pwr_o`=1 and `fetch_en_o`=0, and this persists for as long as no run pulse arrives.
- R5: A run pulse (`run_i`=1 at a rising edge) in low power gives `fetch_en_o`=1 and `low_pwr_o`=0 from the next cycle on.
- R6: A run pulse while running, or while in either hold state, has no effect on the outputs. A run pulse seen during cold hold does not skip low power.
- R7: A low level on the reset pin, once it has passed the two synchronizer stages, forces warm hold from low power or from run. Warm hold shows `fetch_en_o`=0, `low_pwr_o`=0 and `rf_rst_o`=1, on the third edge after the pin falls.
- R8: When the synchronized pin is high again, warm hold moves directly to run (`fetch_en_o`=1) with no run pulse needed.
- R9: `rf_rst_o` is 1 in both hold states and for exactly 4 further cycles after the sequencer leaves either of them. After that it is 0.
- R10: `ip_init_o` always equals the reset vector, which is all zeros by default.
- R11: If a synchronized low pin and a run pulse reach the state machine in the same cycle in low power, the pin wins and the sequencer enters warm hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, synchronous; block reset |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| run_i | input | 1 | Run command pulse that wakes the core from low power |
| fetch_en_o | output | 1 | Instruction fetch and pointer advance enable |
| low_pwr_o | output | 1 | Core is parked in the low-power state |
| rf_rst_o | output | 1 | Register-file reset |
| ip_init_o | output | IP_W | Instruction pointer value loaded on reset |

## Verification
The run pulse and the synchronized reset pin can both reach the state machine in the same cycle while it sits in low power. The bench provokes this by dropping the pin and then raising `run_i` exactly two edges later, so that both arrive together. It then judges that the warm-hold outputs appear and that fetch stays off. A second collision is a run pulse that lands while the sequencer is in a hold state. That pulse must not alter the path taken after release, and the per-cycle reference model compares every output on every clock through these and random sequences.

// File: rtl/rstseq_pkg.sv
// Package: shared state type and helpers for the reset sequencer.
// Assumes two bits suffice to encode the four sequencer states.
package rstseq_pkg;

    typedef enum logic [1:0] {
        SEQ_COLD_HOLD = 2'd0,
        SEQ_WARM_HOLD = 2'd1,
        SEQ_LOW_POWER = 2'd2,
        SEQ_RUN       = 2'd3
    } seq_state_e;

    // True for either of the two hold states.
    function automatic logic seq_is_hold(seq_state_e s);
        return (s == SEQ_COLD_HOLD) || (s == SEQ_WARM_HOLD);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Module: multi-stage synchronizer for the asynchronous reset pin.
// Assumes STAGES >= 2. During power-on reset every stage clears to 0,
// so the pin is treated as asserted until fresh samples pass through.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw pin level through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_fsm.sv
// Module: four-state reset sequencer.
// Assumes pin_ok_i is already synchronized (1 = pin released). The pin
// takes priority over run_i, and cold hold waits for the pin release.
module rstseq_fsm
    import rstseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       pin_ok_i,
    input  logic       run_i,
    output seq_state_e state_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state selection; a low pin outranks the run command.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_COLD_HOLD: if (pin_ok_i) state_d = SEQ_LOW_POWER;
            SEQ_WARM_HOLD: if (pin_ok_i) state_d = SEQ_RUN;
            SEQ_LOW_POWER: begin
                if (!pin_ok_i)  state_d = SEQ_WARM_HOLD;
                else if (run_i) state_d = SEQ_RUN;
            end
            SEQ_RUN:       if (!pin_ok_i) state_d = SEQ_WARM_HOLD;
            default:       state_d = SEQ_COLD_HOLD;
        endcase
    end

    // State register; power-on reset always lands in cold hold.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            state_q <= SEQ_COLD_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rstseq_rfhold.sv
// Module: register-file reset stretcher.
// Holds its output high in any hold state and for TAIL_CYC cycles
// after the sequencer leaves one. Assumes TAIL_CYC >= 1.
module rstseq_rfhold
    import rstseq_pkg::*;
#(
    parameter int TAIL_CYC = 4
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  seq_state_e state_i,
    output logic       rf_rst_o
);

    localparam int CW = $clog2(TAIL_CYC + 1);
    localparam logic [CW-1:0] TAIL_LOAD = CW'(TAIL_CYC);

    logic [CW-1:0] tail_q;
    logic          in_hold;

    assign in_hold = seq_is_hold(state_i);

    // Reload the tail while holding, then count it down to zero.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            tail_q <= TAIL_LOAD;
        end else if (in_hold) begin
            tail_q <= TAIL_LOAD;
        end else if (tail_q != '0) begin
            tail_q <= tail_q - 1'b1;
        end
    end

    assign rf_rst_o = in_hold || (tail_q != '0);

endmodule

// File: rtl/rstseq_top.sv
// Module: cold/warm reset sequencer top.
// Synchronizes the reset pin, runs the state machine and stretches the
// register-file reset. Assumes por_n_i is synchronous to clk_i.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int          IP_W        = 64,
    parameter logic [63:0] RESET_VEC   = 64'h0,
    parameter int          SYNC_STAGES = 2,
    parameter int          RF_TAIL     = 4
) (
    input  logic            clk_i,
    input  logic            por_n_i,
    input  logic            rst_pin_n_i,
    input  logic            run_i,
    output logic            fetch_en_o,
    output logic            low_pwr_o,
    output logic            rf_rst_o,
    output logic [IP_W-1:0] ip_init_o
);

    logic       pin_ok;
    seq_state_e state_q;

    rstseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .d_i     (rst_pin_n_i),
        .q_o     (pin_ok)
    );

    rstseq_fsm fsm_i (
        .clk_i    (clk_i),
        .por_n_i  (por_n_i),
        .pin_ok_i (pin_ok),
        .run_i    (run_i),
        .state_o  (state_q)
    );

    rstseq_rfhold #(.TAIL_CYC(RF_TAIL)) rfhold_i (
        .clk_i    (clk_i),
        .por_n_i  (por_n_i),
        .state_i  (state_q),
        .rf_rst_o (rf_rst_o)
    );

    // Output decode from the sequencer state.
    assign fetch_en_o = (state_q == SEQ_RUN);
    assign low_pwr_o  = (state_q == SEQ_LOW_POWER);
    assign ip_init_o  = RESET_VEC[IP_W-1:0];

endmodule

// File: rtl/rstseq_checker.sv
// Module: property checker for rstseq_top, attached by bind.
// Assumes it observes the synchronized pin and the state register.
module rstseq_checker
    import rstseq_pkg::*;
(
    input logic       clk_i,
    input logic       por_n_i,
    input logic       pin_ok,
    input logic       run_i,
    input seq_state_e state_q,
    input logic       fetch_en_o,
    input logic       low_pwr_o,
    input logic       rf_rst_o
);

    // R1: power-on reset forces the cold-hold outputs one cycle later.
    p_cold_entry_r1: assert property (@(posedge clk_i)
        !por_n_i |=> (!fetch_en_o && !low_pwr_o && rf_rst_o));

    // R3: cold hold persists while the synchronized pin is low.
    p_cold_stays_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_q == SEQ_COLD_HOLD && !pin_ok) |=> (state_q == SEQ_COLD_HOLD));

    // R4: fetch and low power are never on together.
    p_lp_excl_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !(fetch_en_o && low_pwr_o));

    // R5: a run pulse in low power with the pin released enables fetch.
    p_wake_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (low_pwr_o && run_i && pin_ok) |=> fetch_en_o);

    // R6: running continues while the pin stays released, run or not.
    p_run_keep_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (fetch_en_o && pin_ok) |=> fetch_en_o);

    // R7 and R11: a low synchronized pin outside hold enters warm hold.
    p_warm_entry_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        ((fetch_en_o || low_pwr_o) && !pin_ok) |=> (state_q == SEQ_WARM_HOLD));

    // R8: warm hold goes straight to run once the pin is released.
    p_warm_exit_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_q == SEQ_WARM_HOLD && pin_ok) |=> fetch_en_o);

    // R9: register-file reset is still on in the first cycle after a hold.
    p_rf_tail_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!seq_is_hold(state_q) && seq_is_hold($past(state_q))) |-> rf_rst_o);

endmodule

bind rstseq_top rstseq_checker chk_i (
    .clk_i      (clk_i),
    .por_n_i    (por_n_i),
    .pin_ok     (pin_ok),
    .run_i      (run_i),
    .state_q    (state_q),
    .fetch_en_o (fetch_en_o),
    .low_pwr_o  (low_pwr_o),
    .rf_rst_o   (rf_rst_o)
);

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed checks on the cold, warm, run and collision cases.
module rstseq_top_tb_top;

    localparam int IP_W = 64;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            pin_n = 1'b1;
    logic            run = 1'b0;
    logic            fetch_en;
    logic            low_pwr;
    logic            rf_rst;
    logic [IP_W-1:0] ip_init;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rstseq_top dut_i (
        .clk_i       (clk),
        .por_n_i     (por_n),
        .rst_pin_n_i (pin_n),
        .run_i       (run),
        .fetch_en_o  (fetch_en),
        .low_pwr_o   (low_pwr),
        .rf_rst_o    (rf_rst),
        .ip_init_o   (ip_init)
    );

    // Reference model: 0 cold hold, 1 warm hold, 2 low power, 3 run.
    int m_st = 0;
    int m_tail = 4;
    bit pin_hist[$] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        bit seen;
        int nxt;
        if (!por_n) begin
            m_st = 0;
            m_tail = 4;
            pin_hist = '{1'b0, 1'b0};
        end else begin
            seen = pin_hist[0];
            nxt = m_st;
            if (m_st == 0)      nxt = seen ? 2 : 0;
            else if (m_st == 1) nxt = seen ? 3 : 1;
            else if (!seen)     nxt = 1;
            else if (m_st == 2 && run) nxt = 3;
            if (m_st <= 1)        m_tail = 4;
            else if (m_tail > 0)  m_tail = m_tail - 1;
            m_st = nxt;
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin_n);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare every output against the model.
    task automatic tick();
        string st_tag;
        @(posedge clk);
        @(negedge clk);
        st_tag = (m_st == 0) ? "R1 cold" : (m_st == 1) ? "R7 warm" :
                 (m_st == 2) ? "R4 low power" : "R5 run";
        chk(fetch_en == (m_st == 3), {st_tag, " fetch_en"}, fetch_en, m_st == 3);
        chk(low_pwr == (m_st == 2), {st_tag, " low_pwr"}, low_pwr, m_st == 2);
        chk(rf_rst == (m_st <= 1 || m_tail != 0), "R9 rf_rst", rf_rst,
            (m_st <= 1 || m_tail != 0));
        chk(ip_init == '0, "R10 ip_init", int'(ip_init[31:0]), 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: power-on with pin held low.
        por_n = 1'b0; pin_n = 1'b0;
        ticks(4);
        chk(!fetch_en && !low_pwr && rf_rst, "R1 reset state", {fetch_en, low_pwr, rf_rst}, 3'b001);

        // R3: pin still low after power-on release keeps cold hold.
        por_n = 1'b1;
        ticks(6);
        chk(!low_pwr && !fetch_en && rf_rst, "R3 cold kept by pin", {fetch_en, low_pwr, rf_rst}, 3'b001);

        // R6: run pulse during cold hold is ignored.
        pin_n = 1'b1; run = 1'b1;
        tick();
        run = 1'b0;
        tick();
        chk(!fetch_en, "R6 run in cold hold", fetch_en, 0);
        tick();
        chk(low_pwr && !fetch_en, "R3 release leads to low power", {fetch_en, low_pwr}, 2'b01);

        // R2: clean power-on; low power on the third edge after release.
        por_n = 1'b0;
        ticks(3);
        por_n = 1'b1;
        ticks(2);
        chk(!low_pwr, "R2 not before third edge", low_pwr, 0);
        tick();
        chk(low_pwr && !fetch_en, "R2 low power on third edge", {fetch_en, low_pwr}, 2'b01);

        // R4: stays in low power without run.
        ticks(10);
        chk(low_pwr && !fetch_en && !rf_rst, "R4 low power persists", {fetch_en, low_pwr, rf_rst}, 3'b010);

        // R5: run pulse wakes the core on the next edge.
        run = 1'b1;
        tick();
        run = 1'b0;
        chk(fetch_en && !low_pwr, "R5 wake", {fetch_en, low_pwr}, 2'b10);

        // R6: run while running is ignored.
        run = 1'b1;
        ticks(2);
        run = 1'b0;
        chk(fetch_en && !low_pwr, "R6 run while running", {fetch_en, low_pwr}, 2'b10);

        // R7: pin low reaches warm hold on the third edge.
        pin_n = 1'b0;
        ticks(2);
        chk(fetch_en, "R7 still running during sync", fetch_en, 1);
        tick();
        chk(!fetch_en && !low_pwr && rf_rst, "R7 warm hold", {fetch_en, low_pwr, rf_rst}, 3'b001);

        // R6: run during warm hold has no effect.
        run = 1'b1;
        tick();
        run = 1'b0;
        chk(!fetch_en && rf_rst, "R6 run in warm hold", {fetch_en, rf_rst}, 2'b01);

        // R8, R9: release restarts directly; rf reset tail of 4 cycles.
        pin_n = 1'b1;
        ticks(3);
        chk(fetch_en && rf_rst, "R8 direct restart", {fetch_en, rf_rst}, 2'b11);
        ticks(3);
        chk(rf_rst, "R9 tail cycle 4", rf_rst, 1);
        tick();
        chk(!rf_rst, "R9 tail over", rf_rst, 0);

        // R11: synchronized pin and run collide in low power.
        por_n = 1'b0;
        ticks(2);
        por_n = 1'b1;
        ticks(8);
        chk(low_pwr, "R11 setup low power", low_pwr, 1);
        pin_n = 1'b0;
        ticks(2);
        run = 1'b1;
        tick();
        run = 1'b0;
        chk(!fetch_en && !low_pwr && rf_rst, "R11 pin beats run", {fetch_en, low_pwr, rf_rst}, 3'b001);
        pin_n = 1'b1;
        ticks(6);

        // Random stretch under the reference model.
        for (int i = 0; i < 600; i++) begin
            por_n = ($urandom_range(0, 39) != 0);
            pin_n = ($urandom_range(0, 9) != 0);
            run   = ($urandom_range(0, 5) == 0);
            tick();
        end
        finish_run();
    end

endmodule